// File: doc/BRIEF.md
# Priority-Based Throttle Request Arbiter

This block sits between several on/off throttle requesters (for example a light and a heavy thermal throttle and one or more over-current throttles) and the clock pulse skippers. Each requester slot holds its own settings: a numeric priority, a CPU clock skip depth in percent and a 2-bit GPU skip level. Software writes a slot through a simple one-cycle configuration write port.

Every cycle the block looks at the active requests. It picks the eligible requester with the largest priority and drives that requester's whole settings vector to registered outputs. The GPU level code is also translated into its skip percentage. When nothing is eligible, the outputs show no throttling.

Top module: `thr_arb`

## Requirements
- R1: Priorities are programmable per requester in the range 1 to 100, and among active requesters a larger value wins.
- R2: When valid, the outputs carry the winning requester's index, its CPU skip percent and its GPU level code, all taken from that requester's configuration.
- R3: A requester whose priority is 0 is disabled and never wins, even when its request is asserted.
- R4: With no eligible requester, o_valid is 0, o_winner is 0, o_cpu_pct is 0, o_gpu_lvl is 0 (NONE) and o_gpu_pct is 0.
- R5: Outputs are registered: a change of i_req is visible on the outputs after exactly one rising clock edge.
- R6: GPU level codes map to o_gpu_pct as 0 (NONE) to 0, 1 (LOW) to 50, 2 (MED) to 75 and 3 (HIGH) to 85.
- R7: A configured priority above 100 is stored as 100, and a configured CPU percent above 100 is stored as 100.
- R8: When active requesters tie on the top priority, the one with the lowest index wins.
- R9: Requests are plain on/off levels: dropping the winner's request hands the output to the next eligible requester, or to the idle state, one edge later.
- R10: After reset every slot has priority 0, CPU percent 0 and level 0, so requests stay without effect until a slot is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_req | input | NUM_REQ | One on/off request per requester |
| i_cfg_we | input | 1 | Write strobe for one configuration slot |
| i_cfg_idx | input | IDX_W | Slot written by i_cfg_we |
| i_cfg_prio | input | 8 | Priority to store (0 disables, saturates at 100) |
| i_cfg_cpu_pct | input | 8 | CPU skip percent to store (saturates at 100) |
| i_cfg_gpu_lvl | input | 2 | GPU level code to store |
| o_valid | output | 1 | A requester won this cycle |
| o_winner | output | IDX_W | Index of the winning requester |
| o_cpu_pct | output | 7 | Winning CPU skip percent |
| o_gpu_lvl | output | 2 | Winning GPU level code |
| o_gpu_pct | output | 7 | GPU skip percent decoded from the level |

## Verification
The assertions check on every cycle that the idle state follows a cycle with no eligible request, that an eligible request always yields a valid output one edge later, that a reported winner was requesting with a nonzero priority, and that an oversized priority write lands as 100. Which requester wins a contest, the tie-break by index, the copied settings and the GPU percent decode are shown only by the bench scenarios, which compare the outputs against a reference model that finds the maximum priority first and then the first index holding it.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;
  localparam int CFG_W    = 8;
  localparam int PCT_W    = 7;
  localparam int LVL_W    = 2;
  localparam int PCT_MAX  = 100;

  localparam logic [LVL_W-1:0] GLVL_NONE = 2'd0;
  localparam logic [LVL_W-1:0] GLVL_LOW  = 2'd1;
  localparam logic [LVL_W-1:0] GLVL_MED  = 2'd2;
  localparam logic [LVL_W-1:0] GLVL_HIGH = 2'd3;

  // Clamp an 8-bit configuration value to the 0..100 range.
  function automatic logic [PCT_W-1:0] sat_100(input logic [CFG_W-1:0] v);
    return (v > CFG_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : v[PCT_W-1:0];
  endfunction

  // Translate a GPU level code to its skip percentage.
  function automatic logic [PCT_W-1:0] gpu_lvl_pct(input logic [LVL_W-1:0] l);
    case (l)
      GLVL_NONE: return PCT_W'(0);
      GLVL_LOW:  return PCT_W'(50);
      GLVL_MED:  return PCT_W'(75);
      default:   return PCT_W'(85);
    endcase
  endfunction
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [CFG_W-1:0]                prio_in,
  input  logic [CFG_W-1:0]                cpu_in,
  input  logic [LVL_W-1:0]                lvl_in,
  output logic [NUM_REQ-1:0][PCT_W-1:0]   prio_q,
  output logic [NUM_REQ-1:0][PCT_W-1:0]   cpu_q,
  output logic [NUM_REQ-1:0][LVL_W-1:0]   lvl_q
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    logic hit;
    assign hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
        cpu_q[g]  <= '0;
        lvl_q[g]  <= GLVL_NONE;
      end else if (hit) begin
        prio_q[g] <= sat_100(prio_in);
        cpu_q[g]  <= sat_100(cpu_in);
        lvl_q[g]  <= lvl_in;
      end
    end
  end
endmodule

// File: rtl/thr_prio_select.sv
module thr_prio_select
  import thr_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0]              req,
  input  logic [NUM_REQ-1:0][PCT_W-1:0]   prio,
  input  logic [NUM_REQ-1:0][PCT_W-1:0]   cpu,
  input  logic [NUM_REQ-1:0][LVL_W-1:0]   lvl,
  output logic                            any_elig,
  output logic [IDX_W-1:0]                win_idx,
  output logic [PCT_W-1:0]                win_cpu,
  output logic [LVL_W-1:0]                win_lvl
);
  logic [PCT_W-1:0] best_p;

  // Scan upward; a strictly larger priority is needed to replace the
  // current best, so on a tie the lower index stays selected.
  always_comb begin
    best_p   = '0;
    win_idx  = '0;
    win_cpu  = '0;
    win_lvl  = GLVL_NONE;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i] && (prio[i] > best_p)) begin
        best_p  = prio[i];
        win_idx = IDX_W'(i);
        win_cpu = cpu[i];
        win_lvl = lvl[i];
      end
    end
    any_elig = (best_p != '0);
  end
endmodule

// File: rtl/thr_arb.sv
module thr_arb
  import thr_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] i_req,
  input  logic               i_cfg_we,
  input  logic [IDX_W-1:0]   i_cfg_idx,
  input  logic [7:0]         i_cfg_prio,
  input  logic [7:0]         i_cfg_cpu_pct,
  input  logic [1:0]         i_cfg_gpu_lvl,
  output logic               o_valid,
  output logic [IDX_W-1:0]   o_winner,
  output logic [6:0]         o_cpu_pct,
  output logic [1:0]         o_gpu_lvl,
  output logic [6:0]         o_gpu_pct
);
  logic [NUM_REQ-1:0][PCT_W-1:0] prio_q;
  logic [NUM_REQ-1:0][PCT_W-1:0] cpu_q;
  logic [NUM_REQ-1:0][LVL_W-1:0] lvl_q;

  // Named internal events, visible to the bound checker.
  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;
  logic [PCT_W-1:0] sel_cpu;
  logic [LVL_W-1:0] sel_lvl;

  thr_cfg_regs #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (i_cfg_we),
    .idx     (i_cfg_idx),
    .prio_in (i_cfg_prio),
    .cpu_in  (i_cfg_cpu_pct),
    .lvl_in  (i_cfg_gpu_lvl),
    .prio_q  (prio_q),
    .cpu_q   (cpu_q),
    .lvl_q   (lvl_q)
  );

  thr_prio_select #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) sel_i (
    .req      (i_req),
    .prio     (prio_q),
    .cpu      (cpu_q),
    .lvl      (lvl_q),
    .any_elig (sel_any),
    .win_idx  (sel_idx),
    .win_cpu  (sel_cpu),
    .win_lvl  (sel_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid   <= 1'b0;
      o_winner  <= '0;
      o_cpu_pct <= '0;
      o_gpu_lvl <= GLVL_NONE;
      o_gpu_pct <= '0;
    end else begin
      o_valid   <= sel_any;
      o_winner  <= sel_any ? sel_idx : '0;
      o_cpu_pct <= sel_any ? sel_cpu : '0;
      o_gpu_lvl <= sel_any ? sel_lvl : GLVL_NONE;
      o_gpu_pct <= sel_any ? gpu_lvl_pct(sel_lvl) : '0;
    end
  end
endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk
  import thr_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_REQ-1:0]            i_req,
  input logic                          i_cfg_we,
  input logic [IDX_W-1:0]              i_cfg_idx,
  input logic [7:0]                    i_cfg_prio,
  input logic [NUM_REQ-1:0][PCT_W-1:0] prio_q,
  input logic                          sel_any,
  input logic                          o_valid,
  input logic [IDX_W-1:0]              o_winner,
  input logic [6:0]                    o_cpu_pct,
  input logic [1:0]                    o_gpu_lvl,
  input logic [6:0]                    o_gpu_pct
);
  // R4: a cycle with nothing eligible leads to the idle output pattern.
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_any |=> (!o_valid && o_winner == '0 && o_cpu_pct == '0 &&
                  o_gpu_lvl == '0 && o_gpu_pct == '0));

  // R5: an eligible request shows as valid after one edge.
  p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |=> o_valid);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_chk
    // R3: a reported winner was requesting with a nonzero priority.
    p_win_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_winner == IDX_W'(g)) |->
        ($past(i_req[g]) && $past(prio_q[g]) != '0));

    // R7: an oversized priority write is stored as 100.
    p_prio_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (i_cfg_we && i_cfg_idx == IDX_W'(g) && i_cfg_prio > 8'd100) |=>
        (prio_q[g] == PCT_W'(100)));
  end
endmodule

bind thr_arb thr_arb_chk #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .i_req      (i_req),
  .i_cfg_we   (i_cfg_we),
  .i_cfg_idx  (i_cfg_idx),
  .i_cfg_prio (i_cfg_prio),
  .prio_q     (prio_q),
  .sel_any    (sel_any),
  .o_valid    (o_valid),
  .o_winner   (o_winner),
  .o_cpu_pct  (o_cpu_pct),
  .o_gpu_lvl  (o_gpu_lvl),
  .o_gpu_pct  (o_gpu_pct)
);

// File: tb/thr_arb_tb_top.sv
`timescale 1ns/1ps
module thr_arb_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  i_req = '0;
  logic          i_cfg_we = 1'b0;
  logic [IW-1:0] i_cfg_idx = '0;
  logic [7:0]    i_cfg_prio = '0;
  logic [7:0]    i_cfg_cpu_pct = '0;
  logic [1:0]    i_cfg_gpu_lvl = '0;
  logic          o_valid;
  logic [IW-1:0] o_winner;
  logic [6:0]    o_cpu_pct;
  logic [1:0]    o_gpu_lvl;
  logic [6:0]    o_gpu_pct;

  always #4 clk = ~clk;

  thr_arb #(.NUM_REQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .i_req(i_req),
    .i_cfg_we(i_cfg_we), .i_cfg_idx(i_cfg_idx), .i_cfg_prio(i_cfg_prio),
    .i_cfg_cpu_pct(i_cfg_cpu_pct), .i_cfg_gpu_lvl(i_cfg_gpu_lvl),
    .o_valid(o_valid), .o_winner(o_winner), .o_cpu_pct(o_cpu_pct),
    .o_gpu_lvl(o_gpu_lvl), .o_gpu_pct(o_gpu_pct)
  );

  typedef struct {
    logic       v;
    int         w;
    int         cpu;
    int         lvl;
    int         gp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  int m_prio[N];
  int m_cpu[N];
  int m_lvl[N];

  function automatic int lvl_to_pct(int l);
    int tbl[4] = '{0, 50, 75, 85};
    return tbl[l];
  endfunction

  // Reference: find the largest active priority, then the first slot with it.
  function automatic exp_t model(logic [N-1:0] r, string tag);
    exp_t e;
    int top = 0;
    e.v = 0; e.w = 0; e.cpu = 0; e.lvl = 0; e.gp = 0; e.tag = tag;
    for (int i = 0; i < N; i++)
      if (r[i] && m_prio[i] > top) top = m_prio[i];
    if (top > 0) begin
      for (int i = N - 1; i >= 0; i--)
        if (r[i] && m_prio[i] == top) e.w = i;
      e.v   = 1;
      e.cpu = m_cpu[e.w];
      e.lvl = m_lvl[e.w];
      e.gp  = lvl_to_pct(e.lvl);
    end
    return e;
  endfunction

  task automatic cfg(int idx, int prio, int cpu, int lvl);
    @(negedge clk);
    i_cfg_we = 1'b1; i_cfg_idx = IW'(idx);
    i_cfg_prio = 8'(prio); i_cfg_cpu_pct = 8'(cpu); i_cfg_gpu_lvl = 2'(lvl);
    m_prio[idx] = (prio > 100) ? 100 : prio;
    m_cpu[idx]  = (cpu > 100) ? 100 : cpu;
    m_lvl[idx]  = lvl;
    @(negedge clk);
    i_cfg_we = 1'b0;
  endtask

  task automatic step(logic [N-1:0] r, string tag);
    @(negedge clk);
    i_req = r;
    sb_q.push_back(model(r, tag));
  endtask

  // Monitor: compare one expected item after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (o_valid !== e.v || int'(o_winner) != e.w || int'(o_cpu_pct) != e.cpu ||
          int'(o_gpu_lvl) != e.lvl || int'(o_gpu_pct) != e.gp) begin
        errors++;
        $display("FAIL %s: got v=%0d w=%0d cpu=%0d lvl=%0d gp=%0d exp v=%0d w=%0d cpu=%0d lvl=%0d gp=%0d",
                 e.tag, o_valid, o_winner, o_cpu_pct, o_gpu_lvl, o_gpu_pct,
                 e.v, e.w, e.cpu, e.lvl, e.gp);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_cpu[i] = 0; m_lvl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R4 reset state
    if (o_valid !== 1'b0 || o_cpu_pct != 0 || o_gpu_lvl != 0 || o_gpu_pct != 0 || o_winner != 0) begin
      errors++;
      $display("FAIL R4 reset: got v=%0d cpu=%0d lvl=%0d gp=%0d exp all 0", o_valid, o_cpu_pct, o_gpu_lvl, o_gpu_pct);
    end
    step(4'b1111, "R10 unconfigured slots ignored");
    step(4'b0000, "R4 idle");

    cfg(0, 80, 50, 1);
    cfg(1, 100, 85, 3);
    cfg(2, 50, 75, 2);
    cfg(3, 0, 30, 3);

    step(4'b0001, "R2 single light");
    // R5: one negedge after driving a new request, output still shows old value
    @(negedge clk);
    i_req = 4'b0000;
    sb_q.push_back(model(4'b0000, "R5 drop seen after one edge"));
    #1;
    checks++;
    if (o_valid !== 1'b1) begin
      errors++;
      $display("FAIL R5 latency: got v=%0d exp 1 before edge", o_valid);
    end
    step(4'b0011, "R1 heavy beats light");
    step(4'b0111, "R1 top of three");
    step(4'b0101, "R1 light beats oc");
    step(4'b1000, "R3 disabled slot");
    step(4'b1100, "R3 disabled loses, R6 MED 75");
    step(4'b0100, "R6 MED level");
    step(4'b0111, "R9 heavy on");
    step(4'b0101, "R9 heavy off hands over");
    step(4'b0000, "R9 all off idle");

    cfg(3, 200, 150, 0);
    step(4'b1000, "R7 saturated cpu, R6 NONE");
    step(4'b1010, "R8 tie at 100 lower index");
    step(4'b1001, "R7 saturated prio beats 80");
    cfg(2, 100, 60, 1);
    step(4'b1110, "R8 three-way tie");
    step(4'b0101, "R1 raised oc wins, R6 LOW 50");
    cfg(1, 0, 85, 3);
    step(4'b0010, "R3 slot disabled by write");

    for (int k = 0; k < 40; k++) step(N'($urandom), "R2 random mix");
    step(4'b0000, "R4 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule